// File: doc/BRIEF.md
# Consecutive-Area Fault Type Classifier

This block takes the output of an upstream diagnosis stage and decides how each reported fault should be recovered. Each fault arrives as a one-cycle strobe together with the index of the area where it was localized. The block has no view of how the fault was detected. It keeps only the most recently faulted area and a count of consecutive faults in that area. From these it chooses one of three actions, in rising order of severity: reset the application registers, reconfigure the area, or relocate the module because the fault is permanent.

The escalation threshold comes in as a live input from an adaptation stage. The adaptation stage lowers it when the fault rate rises and raises it when the rate falls, so the classifier follows the environment without being rebuilt. Setting the threshold to 2 gives the simple scheme in which the second fault in an area counts as permanent.

Each decision is issued once, one cycle after its strobe. It is presented as a one-hot action vector, a 2-bit type code and the area index, so a recovery stage can act on it directly.

Top module: `fault_sorter`

## Requirements
- R1: The first accepted fault after reset always produces a register-reset action (type code 0, one-hot bit 0).
- R2: A fault whose area differs from the most recent faulty area produces a register-reset action and restarts the consecutive count at 1 for the new area.
- R3: A fault in the same area as the most recent one raises the consecutive count by one. If the new count is below the threshold, it produces a reconfigure action (type code 1, one-hot bit 1).
- R4: A same-area fault whose new count is greater than or equal to the threshold produces a relocate action (type code 2, one-hot bit 2). With a threshold of 2, the second fault in an area relocates.
- R5: After a relocate action, no area is remembered, so the next fault in any area produces a register-reset action.
- R6: The threshold is sampled on the cycle of each strobe. A change takes effect on the very next comparison. Lowering it below the running count makes the next same-area fault relocate.
- R7: While the enable input is low, strobes are ignored. No action is issued and the stored area and count stay unchanged.
- R8: An action is valid for exactly one cycle, in the cycle after the accepted strobe. It carries the area index of that strobe. Strobes on back-to-back cycles each produce their own action.
- R9: The one-hot action vector has exactly one bit set while valid and is all zero otherwise. Its set bit position equals the type code (0 register, 1 configuration, 2 permanent). Code 3 never appears.
- R10: During and just after reset, no action is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Classifier enable; strobes are ignored while low |
| flt_stb | input | 1 | One-cycle fault-detected strobe |
| flt_area | input | AREA_W | Index of the faulty area |
| thr_k | input | K_W | Consecutive-fault threshold for relocation |
| act_valid | output | 1 | Action valid, one cycle after an accepted strobe |
| act_onehot | output | 3 | Action vector: bit0 reset registers, bit1 reconfigure, bit2 relocate |
| act_kind | output | 2 | Fault type code: 0 register, 1 configuration, 2 permanent |
| act_area | output | AREA_W | Area index the action applies to |

## Verification
Two things can land on the same cycle. One is a threshold update from the adaptation stage. The other is a same-area strobe, which is compared against that new threshold. The bench provokes this by changing `thr_k` on the strobe cycle itself, after a run has built up a count. It lowers the threshold below the count, and it also raises it just before the count would have reached the old value. The scoreboard model holds the expected action in each case: relocation at once, or a further reconfigure. Back-to-back strobes, where a decision is being emitted while the next one is being made, are judged the same way, with each result compared in its own cycle.

// File: rtl/fsort_pkg.sv
package fsort_pkg;
   typedef enum logic [1:0] {
      FK_REG  = 2'd0,
      FK_CFG  = 2'd1,
      FK_PERM = 2'd2
   } fkind_t;
   localparam int unsigned NUM_ACT = 3;
endpackage

// File: rtl/fsort_decide.sv
module fsort_decide
   import fsort_pkg::*;
#(
   parameter int unsigned AREA_W = 4,
   parameter int unsigned K_W    = 4
)(
   input  logic              hist_valid,
   input  logic [AREA_W-1:0] hist_area,
   input  logic [K_W-1:0]    hist_cnt,
   input  logic [AREA_W-1:0] area,
   input  logic [K_W-1:0]    thr_k,
   output fkind_t            kind,
   output logic [K_W-1:0]    cnt_next
);
   logic same;

   always_comb begin
      same     = hist_valid && (area == hist_area);
      cnt_next = hist_cnt + K_W'(1);
      if (!same)
         kind = FK_REG;
      else if (cnt_next >= thr_k)
         kind = FK_PERM;
      else
         kind = FK_CFG;
   end
endmodule

// File: rtl/fsort_history.sv
module fsort_history
   import fsort_pkg::*;
#(
   parameter int unsigned AREA_W = 4,
   parameter int unsigned K_W    = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  fkind_t            kind,
   input  logic [AREA_W-1:0] area,
   input  logic [K_W-1:0]    cnt_next,
   output logic              hist_valid,
   output logic [AREA_W-1:0] hist_area,
   output logic [K_W-1:0]    hist_cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_valid <= 1'b0;
         hist_area  <= '0;
         hist_cnt   <= '0;
      end else if (take) begin
         unique case (kind)
            FK_REG: begin
               hist_valid <= 1'b1;
               hist_area  <= area;
               hist_cnt   <= K_W'(1);
            end
            FK_CFG: begin
               hist_cnt   <= cnt_next;
            end
            default: begin
               hist_valid <= 1'b0;
               hist_area  <= '0;
               hist_cnt   <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/fsort_emit.sv
module fsort_emit
   import fsort_pkg::*;
#(
   parameter int unsigned AREA_W = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  fkind_t             kind,
   input  logic [AREA_W-1:0]  area,
   output logic               act_valid,
   output logic [NUM_ACT-1:0] act_onehot,
   output logic [1:0]         act_kind,
   output logic [AREA_W-1:0]  act_area
);
   logic [NUM_ACT-1:0] oh_d;

   for (genvar i = 0; i < NUM_ACT; i++) begin : g_oh
      assign oh_d[i] = take && (kind == fkind_t'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_valid  <= 1'b0;
         act_onehot <= '0;
         act_kind   <= '0;
         act_area   <= '0;
      end else begin
         act_valid  <= take;
         act_onehot <= oh_d;
         if (take) begin
            act_kind <= kind;
            act_area <= area;
         end
      end
   end
endmodule

// File: rtl/fault_sorter.sv
module fault_sorter
   import fsort_pkg::*;
#(
   parameter int unsigned AREA_W = 4,
   parameter int unsigned K_W    = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              flt_stb,
   input  logic [AREA_W-1:0] flt_area,
   input  logic [K_W-1:0]    thr_k,
   output logic              act_valid,
   output logic [2:0]        act_onehot,
   output logic [1:0]        act_kind,
   output logic [AREA_W-1:0] act_area
);
   if (AREA_W < 1) begin : g_bad_area
      $error("fault_sorter: AREA_W must be at least 1");
   end
   if (K_W < 2) begin : g_bad_k
      $error("fault_sorter: K_W must be at least 2");
   end

   logic              take;
   logic              hist_valid;
   logic [AREA_W-1:0] hist_area;
   logic [K_W-1:0]    hist_cnt;
   logic [K_W-1:0]    cnt_next;
   fkind_t            kind;

   assign take = flt_stb && enable;

   fsort_decide #(.AREA_W(AREA_W), .K_W(K_W)) u_decide (
      .hist_valid (hist_valid),
      .hist_area  (hist_area),
      .hist_cnt   (hist_cnt),
      .area       (flt_area),
      .thr_k      (thr_k),
      .kind       (kind),
      .cnt_next   (cnt_next)
   );

   fsort_history #(.AREA_W(AREA_W), .K_W(K_W)) u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .kind       (kind),
      .area       (flt_area),
      .cnt_next   (cnt_next),
      .hist_valid (hist_valid),
      .hist_area  (hist_area),
      .hist_cnt   (hist_cnt)
   );

   fsort_emit #(.AREA_W(AREA_W)) u_emit (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .kind       (kind),
      .area       (flt_area),
      .act_valid  (act_valid),
      .act_onehot (act_onehot),
      .act_kind   (act_kind),
      .act_area   (act_area)
   );
endmodule

// File: rtl/fsort_chk.sv
module fsort_chk #(
   parameter int unsigned AREA_W = 4,
   parameter int unsigned K_W    = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              flt_stb,
   input logic [AREA_W-1:0] flt_area,
   input logic [K_W-1:0]    thr_k,
   input logic              act_valid,
   input logic [2:0]        act_onehot,
   input logic [1:0]        act_kind,
   input logic [AREA_W-1:0] act_area
);
   assert_onehot_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> $countones(act_onehot) == 1);

   assert_onehot_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !act_valid |-> act_onehot == 3'b000);

   assert_kind_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> (act_kind != 2'd3) && (act_onehot == (3'b001 << act_kind)));

   assert_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> $past(flt_stb && enable));

   assert_area_R8: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> act_area == $past(flt_area));

   assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(enable) |-> !act_valid);
endmodule

bind fault_sorter fsort_chk #(.AREA_W(AREA_W), .K_W(K_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .flt_stb    (flt_stb),
   .flt_area   (flt_area),
   .thr_k      (thr_k),
   .act_valid  (act_valid),
   .act_onehot (act_onehot),
   .act_kind   (act_kind),
   .act_area   (act_area)
);

// File: tb/tb_fault_sorter.sv
module tb_fault_sorter;
   localparam int unsigned AREA_W = 4;
   localparam int unsigned K_W    = 4;
   localparam time CLK_PER = 10ns;
   localparam int  WDOG    = 5000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enable = 1'b0;
   logic              flt_stb = 1'b0;
   logic [AREA_W-1:0] flt_area = '0;
   logic [K_W-1:0]    thr_k = K_W'(3);
   logic              act_valid;
   logic [2:0]        act_onehot;
   logic [1:0]        act_kind;
   logic [AREA_W-1:0] act_area;

   fault_sorter #(.AREA_W(AREA_W), .K_W(K_W)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .flt_stb(flt_stb),
      .flt_area(flt_area), .thr_k(thr_k), .act_valid(act_valid),
      .act_onehot(act_onehot), .act_kind(act_kind), .act_area(act_area)
   );

   always #(CLK_PER/2) clk = ~clk;

   typedef struct {
      int          due;
      logic [1:0]  kind;
      logic [AREA_W-1:0] area;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;

   // bench model of the history
   bit              m_valid = 1'b0;
   logic [AREA_W-1:0] m_area = '0;
   int              m_cnt = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [AREA_W-1:0] a, input int k, input bit en,
                       input string tag);
      exp_t e;
      @(negedge clk);
      flt_stb  = 1'b1;
      flt_area = a;
      thr_k    = K_W'(k);
      enable   = en;
      if (en) begin
         e.due  = cyc + 1;
         e.area = a;
         e.tag  = tag;
         if (!m_valid || m_area != a) begin
            e.kind  = 2'd0;
            m_valid = 1'b1;
            m_area  = a;
            m_cnt   = 1;
         end else if (m_cnt + 1 >= k) begin
            e.kind  = 2'd2;
            m_valid = 1'b0;
            m_cnt   = 0;
         end else begin
            e.kind  = 2'd1;
            m_cnt   = m_cnt + 1;
         end
         exp_q.push_back(e);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         flt_stb = 1'b0;
         enable  = 1'b1;
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
               exp_t e;
               e = exp_q.pop_front();
               check(act_valid === 1'b1, e.tag, "valid", int'(act_valid), 1);
               check(act_kind === e.kind, e.tag, "kind", int'(act_kind), int'(e.kind));
               check(act_onehot === (3'b001 << e.kind), "R9", "onehot",
                     int'(act_onehot), int'(3'b001 << e.kind));
               check(act_area === e.area, "R8", "area", int'(act_area), int'(e.area));
            end else begin
               check(act_valid === 1'b0 && act_onehot === 3'b000, "R8",
                     "unexpected action", int'(act_valid), 0);
            end
         end
      end
   end

   // watchdog
   initial begin
      for (int i = 0; i < WDOG; i++) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(act_valid === 1'b0 && act_onehot === 3'b000, "R10", "reset valid",
            int'(act_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(act_valid === 1'b0, "R10", "post-reset valid", int'(act_valid), 0);

      // R1 first fault, R3 reconfigure, R4 relocate at K=3, R5 fresh start
      send(4'd5, 3, 1'b1, "R1"); idle(1);
      send(4'd5, 3, 1'b1, "R3"); idle(1);
      send(4'd5, 3, 1'b1, "R4"); idle(1);
      send(4'd5, 3, 1'b1, "R5"); idle(1);
      // R2 area change restarts count
      send(4'd7, 3, 1'b1, "R2"); idle(1);
      send(4'd7, 3, 1'b1, "R3"); idle(1);
      send(4'd4, 3, 1'b1, "R2"); idle(1);
      send(4'd4, 3, 1'b1, "R3"); idle(1);
      // R6 lowered K below running count (count would be 3, K=2)
      send(4'd4, 2, 1'b1, "R6"); idle(1);
      // R4 with K=2: second fault relocates
      send(4'd9, 2, 1'b1, "R2"); idle(1);
      send(4'd9, 2, 1'b1, "R4"); idle(1);
      // R7 disabled strobes ignored
      send(4'd3, 3, 1'b1, "R5"); idle(1);
      send(4'd3, 3, 1'b0, "R7");
      send(4'd3, 3, 1'b0, "R7");
      send(4'd3, 3, 1'b0, "R7"); idle(2);
      send(4'd3, 3, 1'b1, "R7"); idle(1);
      // R6 raised K on the strobe cycle: count 3 < 5 stays reconfigure
      send(4'd3, 5, 1'b1, "R6"); idle(1);
      send(4'd3, 5, 1'b1, "R6"); idle(1);
      send(4'd3, 5, 1'b1, "R4"); idle(1);
      // R8 back-to-back strobes, max area index
      send(4'd15, 4, 1'b1, "R8");
      send(4'd15, 4, 1'b1, "R8");
      send(4'd0,  4, 1'b1, "R8");
      send(4'd15, 4, 1'b1, "R8");
      send(4'd15, 2, 1'b1, "R6");
      idle(4);
      check(exp_q.size() == 0, "R8", "pending items", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule